// File: doc/BRIEF.md
# Block-Circulant Shift-Add Fully-Connected Unit

This block computes one fully-connected layer, y = ReLU(Wx + v), and contains no multiplier. The weight matrix is divided into k×k tiles, and each tile is circulant. A tile therefore travels as a single vector of k compressed weight codes, and the unit rebuilds the tile by rotating indices as it computes. Every weight is a signed power of two. Each product is formed by arithmetically shifting the activation and then negating it when the sign bit asks for that. An adder tree sums the k terms of each row.

Upstream logic sends one tile column per beat. A beat pairs a block of k activations with the k codes that define the tile. For each output block row, the unit takes every input block in turn, then one bias beat holding k row biases. It then emits one vector of k results. Tile size k and the two block counts are loaded at a start pulse and stay fixed until the layer completes. Any tile size that is a power of two between 4 and the compile-time maximum is allowed.

Top module: `bcsa_fc`

## Requirements
- R1: After reset the unit is idle. `out_valid`, `done`, `act_ready`, `wgt_ready` and `bias_ready` are low.
- R2: A 6-bit weight code uses bit 5 as sign, bit 4 as zero flag and bits 3:0 as exponent e. Its term is (x >>> e), arithmetic and rounding toward minus infinity, negated when bit 5 is set. It is 0 when bit 4 is set.
- R3: Inside a tile, the term for output row i and input column j uses the code at lane index (j − i) mod k of the weight beat.
- R4: A row accumulates over `cfg_nin`+1 input beats. The layer produces `cfg_nout`+1 output vectors. The row accumulators start from zero for every output block row.
- R5: Each 32-bit signed row accumulator saturates after each input beat. The bias is then added with saturation, and a negative result is replaced by 0.
- R6: k = 2^`cfg_klog2`, with `cfg_klog2` from 2 to log2(KMAX). Activations and codes in lanes k and above do not affect any result. Output lanes k and above read 0.
- R7: An activation beat and a weight beat are taken together, and only while a row is accumulating. A bias beat is taken once per row, after the row's last input beat. A presented output keeps `out_valid` high and `out_data` unchanged until `out_ready`.
- R8: `done` is high for exactly one cycle, the cycle after the final output vector is accepted. A start pulse or configuration change during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a layer when idle |
| cfg_klog2 | input | KLW | log2 of tile size k |
| cfg_nin | input | CNT_W | Input blocks per row minus one |
| cfg_nout | input | CNT_W | Output block rows minus one |
| act_valid | input | 1 | Activation beat valid |
| act_ready | output | 1 | Activation beat accepted |
| act_data | input | KMAX*16 | Activation lanes, lane j at bits 16j+15:16j |
| wgt_valid | input | 1 | Weight beat valid |
| wgt_ready | output | 1 | Weight beat accepted |
| wgt_data | input | KMAX*6 | Tile-defining codes, lane j at bits 6j+5:6j |
| bias_valid | input | 1 | Bias beat valid |
| bias_ready | output | 1 | Bias beat accepted |
| bias_data | input | KMAX*32 | Row biases, row i at bits 32i+31:32i |
| out_valid | output | 1 | Result vector valid |
| out_ready | input | 1 | Result vector accepted |
| out_data | output | KMAX*32 | Row results, row i at bits 32i+31:32i |
| done | output | 1 | One-cycle end-of-layer pulse |

## Verification
A start request and an accumulation handshake can land on the same clock edge. The bench provokes this by raising `start` with altered configuration values directly after an input beat of a running layer. The run passes only if the result vectors still match a reference built from the original configuration and `done` pulses once. Output backpressure comes from a random `out_ready`. While an output stalls, the bench checks on every clock that the held vector stays unchanged.

// File: rtl/bcsa_pkg.sv
`timescale 1ns/1ps
package bcsa_pkg;
  localparam int ACT_W  = 16;
  localparam int ACC_W  = 32;
  localparam int EXP_W  = 4;
  localparam int CODE_W = EXP_W + 2;

  typedef logic signed [ACT_W-1:0] act_t;
  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic [CODE_W-1:0]       code_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_BIAS, ST_OUT} phase_e;

  // code: [5] sign, [4] zero flag, [3:0] right-shift amount
  function automatic logic signed [ACT_W:0] shift_term(code_t c, act_t x);
    logic signed [ACT_W:0] mag;
    mag = $signed({x[ACT_W-1], x}) >>> c[EXP_W-1:0];
    if (c[EXP_W]) return '0;
    return c[EXP_W+1] ? -mag : mag;
  endfunction

  function automatic acc_t sat_add(acc_t a, acc_t b);
    logic signed [ACC_W:0] s;
    s = $signed({a[ACC_W-1], a}) + $signed({b[ACC_W-1], b});
    if (s[ACC_W] != s[ACC_W-1])
      return s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    return s[ACC_W-1:0];
  endfunction

  function automatic acc_t relu(acc_t v);
    return v[ACC_W-1] ? '0 : v;
  endfunction
endpackage

// File: rtl/bcsa_lane.sv
`timescale 1ns/1ps
module bcsa_lane import bcsa_pkg::*; #(
  parameter int KMAX = 8,
  parameter int ROW  = 0,
  localparam int LOGK = $clog2(KMAX)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LOGK-1:0]         kmask,
  input  logic [KMAX*ACT_W-1:0]   xv,
  input  logic [KMAX*CODE_W-1:0]  wv,
  input  logic                    acc_clr,
  input  logic                    acc_en,
  input  logic                    res_ld,
  input  acc_t                    bias,
  output acc_t                    res
);
  acc_t acc_q, res_q, bsum;
  logic [LOGK-1:0] idx;
  logic row_active;

  assign row_active = ((LOGK'(ROW) & ~kmask) == '0);

  // rebuild this row of the circulant tile and sum shifted terms
  always_comb begin
    bsum = '0;
    idx  = '0;
    for (int j = 0; j < KMAX; j++) begin
      idx = LOGK'(j - ROW) & kmask;
      if ((LOGK'(j) & ~kmask) == '0)
        bsum = bsum + ACC_W'(shift_term(wv[idx*CODE_W +: CODE_W],
                                        xv[j*ACT_W +: ACT_W]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (acc_clr)     acc_q <= '0;
      else if (acc_en) acc_q <= sat_add(acc_q, bsum);
      if (res_ld)      res_q <= row_active ? relu(sat_add(acc_q, bias)) : '0;
    end
  end

  assign res = res_q;

  // R4
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_q == '0));
  // R6
  idle_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ld && !row_active) |=> (res_q == '0));
endmodule

// File: rtl/bcsa_ctrl.sv
`timescale 1ns/1ps
module bcsa_ctrl import bcsa_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int LOGK  = 3,
  parameter int KLW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KLW-1:0]   cfg_klog2,
  input  logic [CNT_W-1:0] cfg_nin,
  input  logic [CNT_W-1:0] cfg_nout,
  input  logic             act_valid,
  input  logic             wgt_valid,
  input  logic             bias_valid,
  input  logic             out_ready,
  output logic             act_ready,
  output logic             wgt_ready,
  output logic             bias_ready,
  output logic             out_valid,
  output logic             done,
  output logic [LOGK-1:0]  kmask,
  output logic             acc_clr,
  output logic             acc_en,
  output logic             res_ld
);
  phase_e ph_q, ph_d;
  logic [CNT_W-1:0] in_cnt_q, out_cnt_q, nin_q, nout_q;
  logic [KLW-1:0]   klog2_q;
  logic done_q;
  logic start_go, xw_fire, bias_fire, out_fire, last_in, last_out;

  assign start_go  = (ph_q == ST_IDLE) && start;
  assign xw_fire   = (ph_q == ST_ACC) && act_valid && wgt_valid;
  assign bias_fire = (ph_q == ST_BIAS) && bias_valid;
  assign out_fire  = (ph_q == ST_OUT) && out_ready;
  assign last_in   = (in_cnt_q == nin_q);
  assign last_out  = (out_cnt_q == nout_q);

  assign act_ready  = (ph_q == ST_ACC) && wgt_valid;
  assign wgt_ready  = (ph_q == ST_ACC) && act_valid;
  assign bias_ready = (ph_q == ST_BIAS);
  assign out_valid  = (ph_q == ST_OUT);
  assign done       = done_q;
  assign kmask      = LOGK'((32'd1 << klog2_q) - 32'd1);
  assign acc_clr    = start_go || (out_fire && !last_out);
  assign acc_en     = xw_fire;
  assign res_ld     = bias_fire;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      ST_IDLE: if (start)                ph_d = ST_ACC;
      ST_ACC:  if (xw_fire && last_in)   ph_d = ST_BIAS;
      ST_BIAS: if (bias_fire)            ph_d = ST_OUT;
      ST_OUT:  if (out_fire)             ph_d = last_out ? ST_IDLE : ST_ACC;
      default:                           ph_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= ST_IDLE;
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
      nin_q     <= '0;
      nout_q    <= '0;
      klog2_q   <= KLW'(LOGK);
      done_q    <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= out_fire && last_out;
      if (start_go) begin
        klog2_q   <= cfg_klog2;
        nin_q     <= cfg_nin;
        nout_q    <= cfg_nout;
        in_cnt_q  <= '0;
        out_cnt_q <= '0;
      end
      if (xw_fire)               in_cnt_q  <= last_in ? '0 : in_cnt_q + 1'b1;
      if (out_fire && !last_out) out_cnt_q <= out_cnt_q + 1'b1;
    end
  end

  // R7
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_ready, bias_ready, out_valid}));
  // R7
  out_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));
  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != ST_IDLE) |=> ($stable(nin_q) && $stable(nout_q) && $stable(klog2_q)));
endmodule

// File: rtl/bcsa_fc.sv
`timescale 1ns/1ps
module bcsa_fc import bcsa_pkg::*; #(
  parameter int KMAX  = 8,
  parameter int CNT_W = 8,
  localparam int LOGK = $clog2(KMAX),
  localparam int KLW  = $clog2(LOGK + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [KLW-1:0]          cfg_klog2,
  input  logic [CNT_W-1:0]        cfg_nin,
  input  logic [CNT_W-1:0]        cfg_nout,
  input  logic                    act_valid,
  output logic                    act_ready,
  input  logic [KMAX*ACT_W-1:0]   act_data,
  input  logic                    wgt_valid,
  output logic                    wgt_ready,
  input  logic [KMAX*CODE_W-1:0]  wgt_data,
  input  logic                    bias_valid,
  output logic                    bias_ready,
  input  logic [KMAX*ACC_W-1:0]   bias_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [KMAX*ACC_W-1:0]   out_data,
  output logic                    done
);
  logic [LOGK-1:0] kmask;
  logic acc_clr, acc_en, res_ld;

  bcsa_ctrl #(.CNT_W(CNT_W), .LOGK(LOGK), .KLW(KLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_klog2(cfg_klog2),
    .cfg_nin(cfg_nin), .cfg_nout(cfg_nout), .act_valid(act_valid),
    .wgt_valid(wgt_valid), .bias_valid(bias_valid), .out_ready(out_ready),
    .act_ready(act_ready), .wgt_ready(wgt_ready), .bias_ready(bias_ready),
    .out_valid(out_valid), .done(done), .kmask(kmask),
    .acc_clr(acc_clr), .acc_en(acc_en), .res_ld(res_ld));

  for (genvar r = 0; r < KMAX; r++) begin : g_row
    bcsa_lane #(.KMAX(KMAX), .ROW(r)) u_lane (
      .clk(clk), .rst_n(rst_n), .kmask(kmask), .xv(act_data), .wv(wgt_data),
      .acc_clr(acc_clr), .acc_en(acc_en), .res_ld(res_ld),
      .bias(bias_data[r*ACC_W +: ACC_W]), .res(out_data[r*ACC_W +: ACC_W]));
  end

  // R7
  out_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
endmodule

// File: tb/bcsa_fc_tb.sv
`timescale 1ns/1ps
module bcsa_fc_tb_top;
  localparam int KM = 8;
  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] cfg_klog2 = 0;
  logic [7:0] cfg_nin = 0, cfg_nout = 0;
  logic act_valid = 0, wgt_valid = 0, bias_valid = 0, out_ready = 0;
  logic act_ready, wgt_ready, bias_ready, out_valid, done;
  logic [KM*16-1:0] act_data = '0;
  logic [KM*6-1:0]  wgt_data = '0;
  logic [KM*32-1:0] bias_data = '0, out_data;

  bcsa_fc dut_i (.clk(clk), .rst_n(rst_n), .start(start), .cfg_klog2(cfg_klog2),
    .cfg_nin(cfg_nin), .cfg_nout(cfg_nout), .act_valid(act_valid), .act_ready(act_ready),
    .act_data(act_data), .wgt_valid(wgt_valid), .wgt_ready(wgt_ready), .wgt_data(wgt_data),
    .bias_valid(bias_valid), .bias_ready(bias_ready), .bias_data(bias_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done));

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0, n_fail = 0;
  int xs[4][KM];
  int wc[3][4][KM];
  longint bs[3][KM];
  logic [KM*32-1:0] expq[$];
  int rows_left = 0;
  logic done_exp = 0, hold_prev = 0;
  logic [KM*32-1:0] held;
  string cur_req = "R1";
  logic finished = 0;

  task automatic check(logic ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic longint ref_term(int code, longint x);
    longint d, q;
    if ((code & 16) != 0) return 0;
    d = longint'(1) << (code & 15);
    q = x / d;
    if (x < 0 && (x % d) != 0) q = q - 1;
    return ((code & 32) != 0) ? -q : q;
  endfunction

  function automatic longint clamp32(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom_range(0, hi - lo));
  endfunction

  // cycle monitor: compares ports against the reference queue on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      check(done == done_exp, "R8 done timing", longint'(done), longint'(done_exp));
      done_exp = 0;
      if (hold_prev) begin
        check(out_valid && out_data == held, "R7 output held", longint'(out_valid), 1);
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(0, "R8 unexpected output", 1, 0);
        end else begin
          logic [KM*32-1:0] e;
          e = expq.pop_front();
          for (int i = 0; i < KM; i++)
            if (out_data[i*32 +: 32] != e[i*32 +: 32]) begin
              check(0, cur_req, longint'($signed(out_data[i*32 +: 32])),
                    longint'($signed(e[i*32 +: 32])));
              break;
            end
          if (out_data == e) check(1, cur_req, 0, 0);
          done_exp = (rows_left == 1);
          rows_left--;
        end
      end
      hold_prev = out_valid && !out_ready;
      held = out_data;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = ($urandom_range(0, 3) != 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  task automatic run_layer(int kl, int nin, int nout, int mode, logic poke, string req);
    int k = 1 << kl;
    cur_req = req;
    for (int ib = 0; ib <= nin; ib++)
      for (int j = 0; j < KM; j++) xs[ib][j] = rnd(-32768, 32767);
    for (int ob = 0; ob <= nout; ob++) begin
      for (int i = 0; i < KM; i++) bs[ob][i] = longint'(rnd(-1000000, 1000000));
      for (int ib = 0; ib <= nin; ib++)
        for (int j = 0; j < KM; j++) wc[ob][ib][j] = rnd(0, 63);
    end
    for (int ob = 0; ob <= nout; ob++)
      for (int ib = 0; ib <= nin; ib++)
        for (int j = 0; j < k; j++) begin
          case (mode)
            1: begin xs[ib][j] = rnd(30000, 32000); wc[ob][ib][j] = 0;  bs[ob][j] = 64'sd2147483600;  end
            2: begin xs[ib][j] = rnd(30000, 32000); wc[ob][ib][j] = 32; bs[ob][j] = -64'sd2147483600; end
            3: begin wc[ob][ib][j] = 16 | rnd(0, 47); end
            4: begin xs[ib][j] = 1000 * (j + 1); wc[ob][ib][j] = (j == 1) ? 0 : 16; bs[ob][j] = 0; end
            default: ;
          endcase
        end
    for (int ob = 0; ob <= nout; ob++) begin
      logic [KM*32-1:0] e = '0;
      for (int i = 0; i < k; i++) begin
        longint acc = 0, r;
        for (int ib = 0; ib <= nin; ib++) begin
          longint s = 0;
          for (int j = 0; j < k; j++)
            s += ref_term(wc[ob][ib][(j - i + k) % k], longint'(xs[ib][j]));
          acc = clamp32(acc + s);
        end
        r = clamp32(acc + bs[ob][i]);
        if (r < 0) r = 0;
        e[i*32 +: 32] = 32'(r);
      end
      expq.push_back(e);
    end
    rows_left = nout + 1;
    cfg_klog2 = 2'(kl); cfg_nin = 8'(nin); cfg_nout = 8'(nout);
    start = 1;
    @(negedge clk);
    start = 0;
    for (int ob = 0; ob <= nout; ob++) begin
      for (int ib = 0; ib <= nin; ib++) begin
        for (int j = 0; j < KM; j++) begin
          act_data[j*16 +: 16] = 16'(xs[ib][j]);
          wgt_data[j*6 +: 6]   = 6'(wc[ob][ib][j]);
        end
        act_valid = 1; wgt_valid = 1; #1;
        while (!(act_ready && wgt_ready)) begin @(negedge clk); #1; end
        @(negedge clk);
        act_valid = 0; wgt_valid = 0;
        if (poke && ob == 0 && ib == 0) begin
          // R8: start with altered configuration while busy
          cfg_klog2 = 2'd2; cfg_nin = 8'd2; cfg_nout = 8'd2; start = 1;
          @(negedge clk);
          start = 0;
        end
      end
      for (int i = 0; i < KM; i++) bias_data[i*32 +: 32] = 32'(bs[ob][i]);
      bias_valid = 1; #1;
      while (!bias_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      bias_valid = 0;
    end
    while (rows_left != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R4 output count", longint'(expq.size()), 0);
    check(!out_valid && !bias_ready, "R8 idle after layer", longint'(out_valid), 0);
  endtask

  initial begin
    act_valid = 1; wgt_valid = 1;
    repeat (3) @(negedge clk);
    check(!out_valid && !done && !act_ready && !wgt_ready && !bias_ready,
          "R1 reset state", longint'(out_valid), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!act_ready && !wgt_ready, "R7 idle ignores beats", longint'(act_ready), 0);
    act_valid = 0; wgt_valid = 0;
    @(negedge clk);
    run_layer(3, 1, 1, 0, 0, "R2 shift terms");
    run_layer(2, 0, 0, 4, 0, "R3 circulant index");
    run_layer(3, 3, 2, 0, 0, "R4 multi-block accumulate");
    run_layer(3, 0, 0, 1, 0, "R5 saturate high");
    run_layer(2, 1, 0, 2, 0, "R5 saturate low relu");
    run_layer(2, 2, 1, 0, 0, "R6 small tile lanes ignored");
    run_layer(3, 0, 1, 3, 1, "R8 busy start ignored");
    run_layer(2, 2, 2, 0, 0, "R2 random k4");
    finish_up();
  end
endmodule